// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs the external bus cycle of a small microcontroller. A cycle always takes four clock phases. The first phase puts the address out, and the other three move the data. For the whole cycle the block drives a 20-bit address bus that is never shared with data. It also drives a 16-bit shared address/data (AD) bus, and each byte lane of that bus has its own output enable. The AD bus can be configured to stay silent in the first phase when the access falls in a chosen address region. This cuts switching activity on that bus and turns it into a plain data bus.

An internal decoder sorts each access into one of five classes: two DRAM-style windows, each set by a base and a size; an upper region, set by a base; a lower region, set by a limit; and "none". Each of the four real regions has its own suppress bit. A pin sampled during reset can override all four suppress bits. In 8-bit mode the low byte lane carries only data. The high byte lane carries address bits 15..8 in every data phase. Read data is captured from the AD input at the end of the third phase and is presented in the fourth.

Top module: `mbc_bus_ctrl`

## Requirements
- R1: An accepted request runs phases T1, T2, T3 and T4 on consecutive clocks. The `phase` output encodes them as IDLE=0, T1=1, T2=2, T3=3, T4=4. The first clock edge that accepts a request moves `phase` from IDLE or T4 to T1.
- R2: `abus` holds the request address from T1 through T4 and reads zero while idle.
- R3: In T1, when the access is not suppressed, `ad_out` carries address bits 15..0 and both `ad_oe_hi` and `ad_oe_lo` are high.
- R4: Regions are checked in priority order: DRAM window 0 first, then DRAM window 1, then upper, then lower. A DRAM window covers [base, base+size). The upper region covers addresses >= `upper_base`. The lower region covers addresses < `lower_limit`. `dis_bits` bit 0 belongs to DRAM window 0, bit 1 to DRAM window 1, bit 2 to upper and bit 3 to lower. If the matched region has its bit set, both enables are low in T1. An address that matches no region is never suppressed.
- R5: If `addr_keep_n` is low at the clock edge where reset is released, all `dis_bits` are ignored until the next reset. Changes to the pin after reset have no effect.
- R6: In a 16-bit write, `ad_out` carries the write data with both enables high during T2, T3 and T4.
- R7: In a read, `ad_oe_lo` is low during T2 to T4, and so is `ad_oe_hi` in 16-bit mode. `rdata` takes `ad_in` at the end of T3, and `rdata_valid` is high during T4 only.
- R8: When `bus_8bit` is high at acceptance, `ad_out[15:8]` carries address bits 15..8 with `ad_oe_hi` high during T2 to T4, whatever the suppress setting. The low lane carries only write data. A read returns `{8'h00, ad_in[7:0]}`.
- R9: A request is accepted only in IDLE or T4. A request held during T1, T2 or T3 does not change the running cycle and starts nothing.
- R10: During and right after reset, `phase` is IDLE, both enables are low, `abus` is zero and `rdata_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Access address |
| req_wdata | input | 16 | Write data |
| bus_8bit | input | 1 | 1 = 8-bit bus mode for this access |
| dis_bits | input | 4 | Per-region address-phase suppress bits |
| addr_keep_n | input | 1 | Override pin, sampled at reset release; low forces address drive |
| dram0_base | input | 20 | DRAM window 0 base |
| dram0_size | input | 20 | DRAM window 0 size |
| dram1_base | input | 20 | DRAM window 1 base |
| dram1_size | input | 20 | DRAM window 1 size |
| upper_base | input | 20 | Lowest address of the upper region |
| lower_limit | input | 20 | First address above the lower region |
| ad_in | input | 16 | Value seen on the AD bus pins |
| abus | output | 20 | Full-cycle address bus |
| ad_out | output | 16 | Value driven onto the AD bus |
| ad_oe_hi | output | 1 | Output enable for AD bits 15..8 |
| ad_oe_lo | output | 1 | Output enable for AD bits 7..0 |
| rdata | output | 16 | Captured read data |
| rdata_valid | output | 1 | High in T4 of a read |
| phase | output | 3 | Current phase code |

## Verification
The cycle context is latched once per access. A wrong value there, or in the latched override, shows up as wrong enables or wrong AD contents in the very phase that depends on it. It appears within one to four clocks of acceptance, so the bench compares both lanes and their enables in every phase of every access. A stuck or skipped phase in the sequencer shows as a wrong `phase` code on the next clock, and as `rdata_valid` missing or out of place in T4. The region boundary addresses used are the last address inside a window, the first address past it, and the exact upper and lower limits. These expose any off-by-one in the decoder as a flipped T1 enable.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    localparam int AW = 20;
    localparam int DW = 16;
    localparam int NREG = 4;
    localparam int HB = DW / 2;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4
    } phase_t;

    typedef enum logic [2:0] {
        RG_DRAM0 = 3'd0,
        RG_DRAM1 = 3'd1,
        RG_UPPER = 3'd2,
        RG_LOWER = 3'd3,
        RG_NONE  = 3'd4
    } region_t;

    // Context of the running cycle, captured at acceptance.
    typedef struct packed {
        logic          wr;
        logic          byte_mode;
        logic          hide;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } cyc_t;

    function automatic logic in_window(input logic [AW-1:0] a,
                                       input logic [AW-1:0] base,
                                       input logic [AW-1:0] size);
        logic [AW:0] top;
        top = {1'b0, base} + {1'b0, size};
        return (a >= base) && ({1'b0, a} < top);
    endfunction

endpackage

// File: rtl/mbc_region_dec.sv
module mbc_region_dec
    import mbc_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] dram0_base,
    input  logic [AW-1:0] dram0_size,
    input  logic [AW-1:0] dram1_base,
    input  logic [AW-1:0] dram1_size,
    input  logic [AW-1:0] upper_base,
    input  logic [AW-1:0] lower_limit,
    output region_t       region
);

    logic [NREG-1:0] hit;

    always_comb begin
        hit[RG_DRAM0] = in_window(addr, dram0_base, dram0_size);
        hit[RG_DRAM1] = in_window(addr, dram1_base, dram1_size);
        hit[RG_UPPER] = (addr >= upper_base);
        hit[RG_LOWER] = (addr < lower_limit);
    end

    // Lowest index wins.
    always_comb begin
        region = RG_NONE;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (hit[i]) region = region_t'(i);
        end
    end

endmodule

// File: rtl/mbc_phase_seq.sv
module mbc_phase_seq
    import mbc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    output logic   accept,
    output phase_t phase
);

    phase_t nxt;

    assign accept = req && (phase == PH_IDLE || phase == PH_T4);

    always_comb begin
        case (phase)
            PH_T1:   nxt = PH_T2;
            PH_T2:   nxt = PH_T3;
            PH_T3:   nxt = PH_T4;
            default: nxt = accept ? PH_T1 : PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end

    a_r1_t1_to_t2: assert property (@(posedge clk) disable iff (rst)
        phase == PH_T1 |=> phase == PH_T2);
    a_r1_t2_to_t3: assert property (@(posedge clk) disable iff (rst)
        phase == PH_T2 |=> phase == PH_T3);
    a_r1_t3_to_t4: assert property (@(posedge clk) disable iff (rst)
        phase == PH_T3 |=> phase == PH_T4);
    a_r9_no_start_midcycle: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_T1 || phase == PH_T2 || phase == PH_T3) |-> !accept);

endmodule

// File: rtl/mbc_bus_ctrl.sv
module mbc_bus_ctrl
    import mbc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          bus_8bit,
    input  logic [NREG-1:0] dis_bits,
    input  logic          addr_keep_n,
    input  logic [AW-1:0] dram0_base,
    input  logic [AW-1:0] dram0_size,
    input  logic [AW-1:0] dram1_base,
    input  logic [AW-1:0] dram1_size,
    input  logic [AW-1:0] upper_base,
    input  logic [AW-1:0] lower_limit,
    input  logic [DW-1:0] ad_in,
    output logic [AW-1:0] abus,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe_hi,
    output logic          ad_oe_lo,
    output logic [DW-1:0] rdata,
    output logic          rdata_valid,
    output logic [2:0]    phase
);

    region_t region;
    phase_t  ph;
    logic    accept;
    logic    force_drive_q;
    logic    hide_now;
    cyc_t    cyc_q;
    logic    data_ph;

    mbc_region_dec u_dec (
        .addr        (req_addr),
        .dram0_base  (dram0_base),
        .dram0_size  (dram0_size),
        .dram1_base  (dram1_base),
        .dram1_size  (dram1_size),
        .upper_base  (upper_base),
        .lower_limit (lower_limit),
        .region      (region)
    );

    mbc_phase_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .accept (accept),
        .phase  (ph)
    );

    // Override pin: the last sample taken while reset is high is kept.
    always_ff @(posedge clk) begin
        if (rst) force_drive_q <= ~addr_keep_n;
    end

    assign hide_now = !force_drive_q && (region != RG_NONE) && dis_bits[region[1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
        end else if (accept) begin
            cyc_q.wr        <= req_write;
            cyc_q.byte_mode <= bus_8bit;
            cyc_q.hide      <= hide_now;
            cyc_q.addr      <= req_addr;
            cyc_q.wdata     <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= (ph == PH_T3) && !cyc_q.wr;
            if (ph == PH_T3 && !cyc_q.wr)
                rdata <= cyc_q.byte_mode ? {{HB{1'b0}}, ad_in[HB-1:0]} : ad_in;
        end
    end

    assign data_ph = (ph == PH_T2) || (ph == PH_T3) || (ph == PH_T4);
    assign phase   = ph;
    assign abus    = (ph == PH_IDLE) ? '0 : cyc_q.addr;

    always_comb begin
        ad_out   = '0;
        ad_oe_hi = 1'b0;
        ad_oe_lo = 1'b0;
        if (ph == PH_T1) begin
            if (!cyc_q.hide) begin
                ad_out   = cyc_q.addr[DW-1:0];
                ad_oe_hi = 1'b1;
                ad_oe_lo = 1'b1;
            end
        end else if (data_ph) begin
            if (cyc_q.byte_mode) begin
                ad_out[DW-1:HB] = cyc_q.addr[DW-1:HB];
                ad_oe_hi        = 1'b1;
            end else if (cyc_q.wr) begin
                ad_out[DW-1:HB] = cyc_q.wdata[DW-1:HB];
                ad_oe_hi        = 1'b1;
            end
            if (cyc_q.wr) begin
                ad_out[HB-1:0] = cyc_q.wdata[HB-1:0];
                ad_oe_lo       = 1'b1;
            end
        end
    end

    a_r2_abus_hold: assert property (@(posedge clk) disable iff (rst)
        data_ph |-> $stable(abus));
    a_r3_t1_addr_drive: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_T1 && ad_oe_lo) |-> (ad_oe_hi && ad_out == abus[DW-1:0]));
    a_r7_read_released: assert property (@(posedge clk) disable iff (rst)
        (data_ph && !cyc_q.wr) |-> !ad_oe_lo);
    a_r7_valid_in_t4: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |-> ph == PH_T4);
    a_r8_high_lane_addr: assert property (@(posedge clk) disable iff (rst)
        (data_ph && cyc_q.byte_mode) |-> (ad_oe_hi && ad_out[DW-1:HB] == abus[DW-1:HB]));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        ph == PH_IDLE |-> (!ad_oe_hi && !ad_oe_lo && abus == '0));

endmodule

// File: tb/tb_mbc_bus_ctrl.sv
module tb_mbc_bus_ctrl;

    logic        clk = 0;
    logic        rst = 1;
    logic        req = 0, req_write = 0, bus_8bit = 0, addr_keep_n = 1;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0, ad_in = '0;
    logic [3:0]  dis_bits = '0;
    logic [19:0] abus;
    logic [15:0] ad_out, rdata;
    logic        ad_oe_hi, ad_oe_lo, rdata_valid;
    logic [2:0]  phase;

    localparam logic [19:0] D0B = 20'h10000, D0S = 20'h10000;
    localparam logic [19:0] D1B = 20'h40000, D1S = 20'h08000;
    localparam logic [19:0] UPB = 20'hF0000, LOL = 20'h02000;

    int  n_run = 0, n_fail = 0;
    bit  done = 0;
    bit  force_bench = 0;

    always #5 clk = ~clk;

    mbc_bus_ctrl dut (
        .clk(clk), .rst(rst), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .bus_8bit(bus_8bit),
        .dis_bits(dis_bits), .addr_keep_n(addr_keep_n),
        .dram0_base(D0B), .dram0_size(D0S), .dram1_base(D1B), .dram1_size(D1S),
        .upper_base(UPB), .lower_limit(LOL), .ad_in(ad_in),
        .abus(abus), .ad_out(ad_out), .ad_oe_hi(ad_oe_hi), .ad_oe_lo(ad_oe_lo),
        .rdata(rdata), .rdata_valid(rdata_valid), .phase(phase)
    );

    // {bus_8bit, write, dis_bits, addr, data}
    localparam int NV = 9;
    localparam logic [41:0] VEC [NV] = '{
        {1'b0, 1'b1, 4'hF, 20'h30000, 16'hA5C3},
        {1'b0, 1'b0, 4'h1, 20'h1234A, 16'h5A3C},
        {1'b0, 1'b1, 4'h2, 20'h47FFF, 16'h1357},
        {1'b0, 1'b0, 4'hF, 20'h48000, 16'h2468},
        {1'b1, 1'b1, 4'h4, 20'hF0000, 16'hBEEF},
        {1'b1, 1'b0, 4'h8, 20'h01FFF, 16'hCAFE},
        {1'b0, 1'b1, 4'hF, 20'h02000, 16'h0F0F},
        {1'b0, 1'b0, 4'h3, 20'hEFFFF, 16'h7E81},
        {1'b1, 1'b1, 4'hE, 20'h10000, 16'h9966}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic exp_hide(input logic [19:0] a, input logic [3:0] d);
        int r;
        if (a >= D0B && {1'b0, a} < {1'b0, D0B} + {1'b0, D0S}) r = 0;
        else if (a >= D1B && {1'b0, a} < {1'b0, D1B} + {1'b0, D1S}) r = 1;
        else if (a >= UPB) r = 2;
        else if (a < LOL) r = 3;
        else r = 4;
        return !force_bench && r < 4 && d[r];
    endfunction

    task automatic issue(input logic m8, input logic wr, input logic [3:0] d,
                         input logic [19:0] a, input logic [15:0] w);
        req = 1; req_write = wr; bus_8bit = m8; dis_bits = d; req_addr = a; req_wdata = w;
    endtask

    task automatic chk_data(input string ph, input logic m8, input logic wr,
                            input logic [19:0] a, input logic [15:0] w);
        chk({"R2 abus ", ph}, abus, a);
        chk({"R7 oe_lo ", ph}, ad_oe_lo, wr);
        if (wr) chk({"R6 lo data ", ph}, ad_out[7:0], w[7:0]);
        if (m8) begin
            chk({"R8 oe_hi ", ph}, ad_oe_hi, 1);
            chk({"R8 hi addr ", ph}, ad_out[15:8], a[15:8]);
        end else begin
            chk({"R7 oe_hi ", ph}, ad_oe_hi, wr);
            if (wr) chk({"R6 hi data ", ph}, ad_out[15:8], w[15:8]);
        end
    endtask

    // Called with the request already on the inputs before a rising edge.
    task automatic follow(input logic m8, input logic wr, input logic [3:0] d,
                          input logic [19:0] a, input logic [15:0] w);
        logic h;
        h = exp_hide(a, d);
        @(posedge clk); #1 req = 0;
        @(negedge clk);
        chk("R1 phase T1", phase, 1);
        chk("R2 abus T1", abus, a);
        chk("R4 oe_hi T1", ad_oe_hi, !h);
        chk("R4 oe_lo T1", ad_oe_lo, !h);
        if (!h) chk("R3 ad T1", ad_out, a[15:0]);
        @(negedge clk);
        ad_in = w;
        chk("R1 phase T2", phase, 2);
        chk_data("T2", m8, wr, a, w);
        @(negedge clk);
        chk("R1 phase T3", phase, 3);
        chk_data("T3", m8, wr, a, w);
        @(negedge clk);
        ad_in = 16'hDEAD;
        chk("R1 phase T4", phase, 4);
        chk_data("T4", m8, wr, a, w);
        chk("R7 valid T4", rdata_valid, !wr);
        if (!wr) chk("R7 R8 rdata", rdata, m8 ? {8'h00, w[7:0]} : w);
    endtask

    task automatic run_vec(input logic [41:0] v);
        @(negedge clk);
        issue(v[41], v[40], v[39:36], v[35:16], v[15:0]);
        follow(v[41], v[40], v[39:36], v[35:16], v[15:0]);
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst = 1; addr_keep_n = pin; req = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        force_bench = !pin;
        @(negedge clk);
        addr_keep_n = !pin;  // later changes must not matter (R5)
        chk("R10 phase idle", phase, 0);
        chk("R10 oe", {ad_oe_hi, ad_oe_lo}, 0);
        chk("R10 abus", abus, 0);
        chk("R10 valid", rdata_valid, 0);
    endtask

    initial begin
        do_reset(1'b1);
        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i]);
            @(negedge clk);
            chk("R9 idle after cycle", phase, 0);
            chk("R2 abus idle", abus, 0);
        end

        // R9: back-to-back start from T4
        run_vec({1'b0, 1'b0, 4'h0, 20'h55555, 16'h1111});
        issue(1'b0, 1'b1, 4'h0, 20'h66666, 16'h2222);
        follow(1'b0, 1'b1, 4'h0, 20'h66666, 16'h2222);
        @(negedge clk);
        chk("R9 idle after back-to-back", phase, 0);

        // R9: request raised during T1 and T2 is ignored
        @(negedge clk);
        issue(1'b0, 1'b1, 4'h0, 20'h33333, 16'h3333);
        @(posedge clk); #1 req = 0;
        @(negedge clk);
        issue(1'b0, 1'b0, 4'h0, 20'h77777, 16'h0);
        @(negedge clk);
        req = 0;
        chk("R9 midcycle phase", phase, 2);
        chk("R9 midcycle abus", abus, 20'h33333);
        @(negedge clk);
        chk("R9 midcycle abus T3", abus, 20'h33333);
        @(negedge clk);
        @(negedge clk);
        chk("R9 no extra cycle", phase, 0);

        // R5: override low at reset forces drive; the pin then rises
        do_reset(1'b0);
        run_vec({1'b0, 1'b1, 4'hF, 20'h12000, 16'h4242});
        run_vec({1'b1, 1'b0, 4'hF, 20'hF8000, 16'h8181});
        // R5: override high at reset; the pin then falls and is ignored
        do_reset(1'b1);
        run_vec({1'b0, 1'b0, 4'h1, 20'h18000, 16'h6543});

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule